// File: doc/BRIEF.md
# Flash Write Status Reporter

This block forms the word a host sees when it reads a flash device while an internal program or erase job runs. No single busy bit carries the progress. The block combines several signals into the returned word: a polling bit that is inverted against the written data, a bit that flips on every read, a second flip bit that reacts only to reads aimed at a suspended sector, a sticky time-limit bit and an erase-window bit. It also drives a registered ready flag. When no job runs, or when a read during suspend targets a sector that is not suspended, the word is the array data supplied by the surrounding logic.

A command decoder pulses `start_op` at the final write strobe of a command sequence. It gives the job type and the data being written with that pulse. The job engine later pulses `op_done`, and the operation timer pulses `timeout` if the job overruns. A reset command returns the block to array reads and clears the time-limit bit. Reads are marked by the active-low `rd_n` strobe, which is sampled on the clock. Each high-to-low transition counts as exactly one read.

Top module: `flash_stat_rpt`

## Requirements
- R1: While `rst` is high, `ready` is 1 and `rdata` is 0. All toggle, timeout and job state is cleared.
- R2: `start_op` makes `ready` 0 after the next edge, and `start_op` wins over `op_done` in the same cycle. `op_done` or `reset_cmd` makes `ready` 1 after the next edge. In that same cycle `rdata` equals `array_data`.
- R3: During a program job (`op_kind`=0), bit 7 of the status word is the inverse of bit 7 of `wr_data`.
- R4: During an erase job (`op_kind`=1) that is not suspended, bit 7 is 0, so the status word is never FFh.
- R5: Bit 6 inverts once for each 1-to-0 transition of `rd_n` while a job is busy and `susp` is 0. Holding `rd_n` low gives no further inversion, and bit 6 holds otherwise.
- R6: While busy with `susp`=1 and `rd_in_susp`=1, bit 7 is 1, bit 2 inverts once per read, and bit 6 holds. With `susp`=1 and `rd_in_susp`=0, `rdata` is `array_data`, and that read leaves bit 2 unchanged.
- R7: A `timeout` pulse while busy sets bit 5, which stays 1 until `reset_cmd`. A `timeout` while ready has no effect: the next job reports bit 5 as 0.
- R8: Bit 3 is 1 during an erase job when `erase_win_open` is 0, and is 0 when the window is open or during a program job.
- R9: The status word has bits 4, 1, 0 and every bit above 7 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_op | input | 1 | Job start pulse (final write strobe of a command) |
| op_kind | input | 1 | 0 = program, 1 = erase |
| wr_data | input | DATA_W | Data being programmed |
| op_done | input | 1 | Job finished pulse |
| timeout | input | 1 | Time limit exceeded pulse |
| reset_cmd | input | 1 | Reset command pulse |
| erase_win_open | input | 1 | Erase acceptance window still open |
| susp | input | 1 | Erase is suspended |
| rd_in_susp | input | 1 | Read address lies in the suspended sector |
| rd_n | input | 1 | Active-low read strobe |
| array_data | input | DATA_W | Array contents at the read address |
| rdata | output | DATA_W | Registered read word (status or array) |
| ready | output | 1 | Registered ready flag (1 = no job running) |

## Verification
The bench builds the block with DATA_W=8. At that width every program data value, all 256 of them, can be started, polled, read once and finished. This checks the inverted polling bit and the return to array data over the full byte. Fixed sequences then cover erase with the window open and closed, suspend reads inside and outside the suspended sector, a held read strobe, a timeout inside a job and a timeout outside a job, and a reset command.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic {KIND_PROG = 1'b0, KIND_ERASE = 1'b1} job_kind_t;
  localparam int POLL_BIT = 7;
  localparam int FLIP_BIT = 6;
  localparam int TMO_BIT  = 5;
  localparam int WIN_BIT  = 3;
  localparam int SUSF_BIT = 2;
endpackage

// File: rtl/fsr_fall_det.sv
module fsr_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall
);
  logic prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= strobe_n;
  end
  assign fall = prev_q & ~strobe_n;
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic state_d,
  output logic state_q
);
  assign state_d = flip ? ~state_q : state_q;
  always_ff @(posedge clk) begin
    if (rst) state_q <= 1'b0;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/fsr_track.sv
module fsr_track
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_op,
  input  job_kind_t kind_in,
  input  logic      poll_in,
  input  logic      op_done,
  input  logic      reset_cmd,
  input  logic      timeout,
  output logic      busy_q,
  output logic      busy_d,
  output job_kind_t kind_d,
  output logic      poll_d,
  output logic      fail_d
);
  job_kind_t kind_q;
  logic      poll_q;
  logic      fail_q;

  always_comb begin
    busy_d = busy_q;
    if (start_op)                   busy_d = 1'b1;
    else if (op_done || reset_cmd)  busy_d = 1'b0;
    kind_d = start_op ? kind_in : kind_q;
    poll_d = start_op ? poll_in : poll_q;
    fail_d = fail_q;
    if (reset_cmd)                  fail_d = 1'b0;
    else if (timeout && busy_q)     fail_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kind_q <= KIND_PROG;
      poll_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
      poll_q <= poll_d;
      fail_q <= fail_d;
    end
  end
endmodule

// File: rtl/flash_stat_rpt.sv
module flash_stat_rpt
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_op,
  input  logic              op_kind,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  input  logic              timeout,
  input  logic              reset_cmd,
  input  logic              erase_win_open,
  input  logic              susp,
  input  logic              rd_in_susp,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  localparam int TOG_N = 2;

  logic              rd_fall;
  logic              busy_q, busy_d, poll_d, fail_d;
  job_kind_t         kind_d;
  logic [TOG_N-1:0]  tog_en, tog_d, tog_q;
  logic [DATA_W-1:0] stat_w, rdata_d;

  fsr_fall_det u_fall (
    .clk(clk), .rst(rst), .strobe_n(rd_n), .fall(rd_fall)
  );

  fsr_track #(.DATA_W(DATA_W)) u_track (
    .clk(clk), .rst(rst), .start_op(start_op), .kind_in(job_kind_t'(op_kind)),
    .poll_in(wr_data[POLL_BIT]), .op_done(op_done), .reset_cmd(reset_cmd),
    .timeout(timeout), .busy_q(busy_q), .busy_d(busy_d), .kind_d(kind_d),
    .poll_d(poll_d), .fail_d(fail_d)
  );

  // index 0: per-read flip, index 1: suspended-sector flip
  assign tog_en[0] = rd_fall & busy_q & ~susp;
  assign tog_en[1] = rd_fall & busy_q & susp & rd_in_susp;

  for (genvar g = 0; g < TOG_N; g++) begin : g_tog
    fsr_toggle u_tog (
      .clk(clk), .rst(rst), .flip(tog_en[g]),
      .state_d(tog_d[g]), .state_q(tog_q[g])
    );
  end

  always_comb begin
    stat_w = '0;
    if (susp)                    stat_w[POLL_BIT] = 1'b1;
    else if (kind_d == KIND_ERASE) stat_w[POLL_BIT] = 1'b0;
    else                         stat_w[POLL_BIT] = ~poll_d;
    stat_w[FLIP_BIT] = tog_d[0];
    stat_w[TMO_BIT]  = fail_d;
    stat_w[WIN_BIT]  = (kind_d == KIND_ERASE) & ~erase_win_open;
    stat_w[SUSF_BIT] = tog_d[1];
    if (!busy_d || (susp && !rd_in_susp)) rdata_d = array_data;
    else                                  rdata_d = stat_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      ready <= 1'b1;
    end else begin
      rdata <= rdata_d;
      ready <= ~busy_d;
    end
  end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_op,
  input logic              op_done,
  input logic              timeout,
  input logic              reset_cmd,
  input logic              susp,
  input logic              rd_n,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rdata,
  input logic              ready
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    start_op |=> !ready);

  assert_done_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_done) && !$past(start_op)) |-> ready);

  assert_ready_array_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ready) |-> rdata == $past(array_data));

  assert_read_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !ready && !$past(ready)
     && !$past(susp) && !$past(susp, 2) && $past(rd_n, 2) && !$past(rd_n))
    |-> rdata[6] != $past(rdata[6]));

  assert_tmo_set_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(timeout) && !$past(ready) && !$past(reset_cmd)
     && !ready && !$past(susp)) |-> rdata[5]);
endmodule

bind flash_stat_rpt fsr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .start_op(start_op), .op_done(op_done),
  .timeout(timeout), .reset_cmd(reset_cmd), .susp(susp), .rd_n(rd_n),
  .array_data(array_data), .rdata(rdata), .ready(ready)
);

// File: tb/sim_flash_stat_rpt.sv
`timescale 1ns/1ps
module sim_flash_stat_rpt;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic start_op = 0, op_kind = 0, op_done = 0, timeout = 0, reset_cmd = 0;
  logic erase_win_open = 0, susp = 0, rd_in_susp = 0, rd_n = 1;
  logic [W-1:0] wr_data = '0, array_data = '0;
  logic [W-1:0] rdata;
  logic ready;
  int total = 0, bad = 0, cyc = 0;
  logic e6 = 0, e2 = 0;

  flash_stat_rpt #(.DATA_W(W)) u0 (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] stat(input logic erase, input logic pbit,
      input logic fl, input logic win_closed, input logic sp);
    logic [W-1:0] s = '0;
    s[7] = sp ? 1'b1 : (erase ? 1'b0 : ~pbit);
    s[6] = e6; s[5] = fl; s[3] = erase & win_closed; s[2] = e2;
    return s;
  endfunction

  task automatic rd_pulse();
    rd_n = 0; tick(); rd_n = 1; tick();
  endtask

  initial begin
    tick(); tick();
    chk("R1 ready", ready, 1); chk("R1 rdata", rdata, 0);
    rst = 0; array_data = 8'hA7; tick();
    chk("R2 idle array", rdata, 8'hA7);

    // exhaustive program sweep
    for (int v = 0; v < 256; v++) begin
      array_data = ~v[7:0]; wr_data = v[7:0]; op_kind = 0;
      start_op = 1; tick(); start_op = 0;
      chk("R2 busy", ready, 0);
      chk("R3 R9 poll word", rdata, stat(0, v[7], 0, 1, 0));
      rd_n = 0; tick(); e6 = ~e6;
      chk("R5 flip", rdata, stat(0, v[7], 0, 1, 0));
      rd_n = 1; tick();
      chk("R5 hold", rdata, stat(0, v[7], 0, 1, 0));
      array_data = v[7:0]; op_done = 1; tick(); op_done = 0;
      chk("R2 done ready", ready, 1); chk("R2 done array", rdata, v[7:0]);
    end

    // start wins over done
    start_op = 1; op_done = 1; op_kind = 0; wr_data = 8'h00; tick();
    start_op = 0; op_done = 0;
    chk("R2 start priority", ready, 0);
    op_done = 1; tick(); op_done = 0;

    // erase
    array_data = 8'hFF; erase_win_open = 1; op_kind = 1;
    start_op = 1; tick(); start_op = 0;
    chk("R4 R8 erase open", rdata, stat(1, 0, 0, 0, 0));
    chk("R4 not FF", rdata == 8'hFF, 0);
    erase_win_open = 0; tick();
    chk("R8 window closed", rdata, stat(1, 0, 0, 1, 0));
    for (int i = 0; i < 3; i++) begin
      rd_n = 0; tick(); e6 = ~e6;
      chk("R5 erase flip", rdata, stat(1, 0, 0, 1, 0));
      rd_n = 1; tick();
    end
    rd_n = 0; tick(); e6 = ~e6; tick(); tick();
    chk("R5 held low one flip", rdata, stat(1, 0, 0, 1, 0));
    rd_n = 1; tick();

    // suspend, in sector
    susp = 1; rd_in_susp = 1; tick();
    chk("R6 susp word", rdata, stat(1, 0, 0, 1, 1));
    for (int i = 0; i < 3; i++) begin
      rd_n = 0; tick(); e2 = ~e2;
      chk("R6 sector flip", rdata, stat(1, 0, 0, 1, 1));
      rd_n = 1; tick();
    end
    rd_in_susp = 0; array_data = 8'h3C; tick();
    chk("R6 outside array", rdata, 8'h3C);
    rd_pulse();
    chk("R6 outside read array", rdata, 8'h3C);
    rd_in_susp = 1; tick();
    chk("R6 outside read no flip", rdata, stat(1, 0, 0, 1, 1));
    susp = 0; rd_in_susp = 0; tick();
    rd_n = 0; tick(); e6 = ~e6;
    chk("R5 resume flip", rdata, stat(1, 0, 0, 1, 0));
    rd_n = 1; tick();

    // timeout
    timeout = 1; tick(); timeout = 0;
    chk("R7 set", rdata, stat(1, 0, 1, 1, 0));
    rd_pulse(); e6 = ~e6;
    chk("R7 sticky", rdata, stat(1, 0, 1, 1, 0));
    reset_cmd = 1; tick(); reset_cmd = 0;
    chk("R2 reset ready", ready, 1); chk("R2 reset array", rdata, 8'h3C);

    // timeout while ready ignored
    timeout = 1; tick(); timeout = 0;
    chk("R7 idle ignore array", rdata, 8'h3C);
    op_kind = 0; wr_data = 8'h80; start_op = 1; tick(); start_op = 0;
    chk("R7 idle timeout ignored", rdata, stat(0, 1, 0, 1, 0));
    op_done = 1; tick(); op_done = 0;

    // reset in the middle of a job
    start_op = 1; tick(); start_op = 0;
    rst = 1; tick();
    chk("R1 mid ready", ready, 1); chk("R1 mid rdata", rdata, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule